// File: doc/BRIEF.md
# Credit-Ranked Variable-Area Configuration Cache

This block tracks which configurations are resident on a reconfigurable fabric. Each configuration takes a different amount of area. A requester presents a configuration identifier and its area. The block answers with a stream of one-cycle events. A resident identifier gives a hit. A miss with enough room gives a load. Otherwise the block gives one or more evictions, one per cycle, followed by the load. The fabric has a fixed number of slots and a fixed total area. The free area is always visible on an output.

Each resident entry holds a credit. A load sets the credit to the entry's area, and a hit sets it back to the stored area. When room is needed, the entry with the smallest credit is removed. Its credit is then subtracted from the credit of every entry that stays. Large and recently used configurations therefore survive longer than small or stale ones. Moving the bitstream and placing it on the fabric are left to other logic, which acts on the event stream.

Top module: `ccache_credit`

## Requirements
- R1: After reset no configuration is resident, `free_area` equals the `AREA` parameter, `req_ready` is high and `evt_valid` is low.
- R2: A request whose identifier is resident produces a single event of kind 0 (hit). The event carries that entry's slot. `free_area` is unchanged, and the entry's credit is restored to its stored area.
- R3: A miss for which `free_area` is at least the requested area and a slot is empty produces a single event of kind 1 (load). The load goes into the lowest-numbered empty slot, with credit equal to the area. `free_area` drops by the requested area.
- R4: A miss that does not fit removes the resident entry with the smallest credit. It emits an event of kind 2 (evict) carrying the victim's identifier and slot. `free_area` grows by the victim's area.
- R5: On each eviction, every remaining resident entry has its credit reduced by the victim's credit.
- R6: Evictions repeat, one per cycle, until the request fits. Then the load event follows.
- R7: When several entries share the smallest credit, the one in the lowest-numbered slot is evicted.
- R8: When every slot is occupied, a miss causes an eviction even if the free area would be enough.
- R9: A request with area zero or area greater than `AREA` produces a single event of kind 3 (reject) carrying the request identifier. It changes no resident entry, credit or `free_area`.
- R10: `req_ready` is low from the cycle after an accepted non-rejected request until the cycle its final hit or load event appears.
- R11: `free_area` never exceeds `AREA`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_id | input | ID_W | Configuration identifier |
| req_size | input | SIZE_W | Area the configuration needs |
| req_ready | output | 1 | Block idle, request will be taken |
| evt_valid | output | 1 | Event present for one cycle |
| evt_kind | output | 2 | 0 hit, 1 load, 2 evict, 3 reject |
| evt_id | output | ID_W | Identifier the event refers to |
| evt_slot | output | IDX_W | Slot the event refers to (0 for reject) |
| free_area | output | AREA_W | Unoccupied fabric area |

## Verification
The hardest cases to reach are those where the credit ranking differs from plain recency. These are a chain of evictions in which credits reduced by an earlier victim decide the next one, and a tie between equal credits. The stimulus first fills the fabric close to its total area with entries of mixed sizes and hits one of them. It then asks for a large configuration that forces two evictions in a row. It also fills every slot while area is still free, and, after a fresh reset, loads two equal-size entries so that their credits tie. A reference model in the bench replays the credit arithmetic and predicts every event in order.

// File: rtl/ccache_pkg.sv
package ccache_pkg;

  typedef enum logic [1:0] {
    EV_HIT    = 2'd0,
    EV_LOAD   = 2'd1,
    EV_EVICT  = 2'd2,
    EV_REJECT = 2'd3
  } ev_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_LOAD
  } st_t;

  // Room for a new entry: enough area and a free slot.
  function automatic logic room_ok(input int unsigned free_a, input int unsigned need,
                                   input logic slot_free);
    return slot_free && (free_a >= need);
  endfunction

  // Survivor credit after a victim with credit v leaves (never below zero).
  function automatic int unsigned credit_drop(input int unsigned c, input int unsigned v);
    return (c > v) ? (c - v) : 0;
  endfunction

  function automatic int unsigned area_add(input int unsigned a, input int unsigned b);
    return a + b;
  endfunction

  function automatic int unsigned area_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/ccache_match.sv
module ccache_match #(
  parameter int SLOTS = 4,
  parameter int ID_W  = 8,
  parameter int IDX_W = 2
) (
  input  logic [SLOTS-1:0]           valid,
  input  logic [SLOTS-1:0][ID_W-1:0] ids,
  input  logic [ID_W-1:0]            key,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx,
  output logic                       has_empty,
  output logic [IDX_W-1:0]           empty_idx
);
  // Scan from the top so the lowest index wins both searches.
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    has_empty = 1'b0;
    empty_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (valid[i] && ids[i] == key) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        has_empty = 1'b1;
        empty_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ccache_victim.sv
module ccache_victim #(
  parameter int SLOTS  = 4,
  parameter int CRED_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [SLOTS-1:0]             valid,
  input  logic [SLOTS-1:0][CRED_W-1:0] credits,
  output logic                         found,
  output logic [IDX_W-1:0]             idx,
  output logic [CRED_W-1:0]            credit
);
  // Strict less-than keeps the earlier slot on equal credit (R7).
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    credit = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (valid[i] && (!found || credits[i] < credit)) begin
        found  = 1'b1;
        idx    = IDX_W'(i);
        credit = credits[i];
      end
    end
  end
endmodule

// File: rtl/ccache_credit.sv
module ccache_credit
  import ccache_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ID_W   = 8,
  parameter int SIZE_W = 8,
  parameter int AREA   = 100,
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int AREA_W = $clog2(AREA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [SIZE_W-1:0] req_size,
  output logic              req_ready,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic [ID_W-1:0]   evt_id,
  output logic [IDX_W-1:0]  evt_slot,
  output logic [AREA_W-1:0] free_area
);

  st_t                          state;
  logic [SLOTS-1:0]             ent_valid;
  logic [SLOTS-1:0][ID_W-1:0]   ent_id;
  logic [SLOTS-1:0][SIZE_W-1:0] ent_size;
  logic [SLOTS-1:0][SIZE_W-1:0] ent_credit;
  logic [ID_W-1:0]              cur_id;
  logic [SIZE_W-1:0]            cur_size;

  logic              m_hit, m_has_empty;
  logic [IDX_W-1:0]  m_hit_idx, m_empty_idx;
  logic              v_found;
  logic [IDX_W-1:0]  v_idx;
  logic [SIZE_W-1:0] v_credit;

  ccache_match #(.SLOTS(SLOTS), .ID_W(ID_W), .IDX_W(IDX_W)) u_match (
    .valid(ent_valid), .ids(ent_id), .key(cur_id),
    .hit(m_hit), .hit_idx(m_hit_idx),
    .has_empty(m_has_empty), .empty_idx(m_empty_idx)
  );

  ccache_victim #(.SLOTS(SLOTS), .CRED_W(SIZE_W), .IDX_W(IDX_W)) u_victim (
    .valid(ent_valid), .credits(ent_credit),
    .found(v_found), .idx(v_idx), .credit(v_credit)
  );

  // Named internal events
  logic size_bad, accept, do_reject, do_hit, room, do_fit, do_evict, do_load;
  assign req_ready = (state == ST_IDLE);
  assign size_bad  = (req_size == '0) || (32'(req_size) > AREA);
  assign accept    = req_valid && req_ready;
  assign do_reject = accept && size_bad;
  assign do_hit    = (state == ST_LOOKUP) && m_hit;
  assign room      = room_ok(32'(free_area), 32'(cur_size), m_has_empty);
  assign do_fit    = (state == ST_EVICT) && room;
  assign do_evict  = (state == ST_EVICT) && !room && v_found;
  assign do_load   = (state == ST_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ent_valid  <= '0;
      ent_id     <= '0;
      ent_size   <= '0;
      ent_credit <= '0;
      cur_id     <= '0;
      cur_size   <= '0;
      free_area  <= AREA_W'(AREA);
      evt_valid  <= 1'b0;
      evt_kind   <= '0;
      evt_id     <= '0;
      evt_slot   <= '0;
    end else begin
      evt_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (do_reject) begin
            evt_valid <= 1'b1;
            evt_kind  <= EV_REJECT;
            evt_id    <= req_id;
            evt_slot  <= '0;
          end else if (accept) begin
            cur_id   <= req_id;
            cur_size <= req_size;
            state    <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (do_hit) begin
            ent_credit[m_hit_idx] <= ent_size[m_hit_idx];
            evt_valid <= 1'b1;
            evt_kind  <= EV_HIT;
            evt_id    <= cur_id;
            evt_slot  <= m_hit_idx;
            state     <= ST_IDLE;
          end else begin
            state <= ST_EVICT;
          end
        end
        ST_EVICT: begin
          if (do_fit) begin
            state <= ST_LOAD;
          end else if (do_evict) begin
            ent_valid[v_idx] <= 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
              if (ent_valid[i] && IDX_W'(i) != v_idx)
                ent_credit[i] <= SIZE_W'(credit_drop(32'(ent_credit[i]), 32'(v_credit)));
            end
            free_area <= AREA_W'(area_add(32'(free_area), 32'(ent_size[v_idx])));
            evt_valid <= 1'b1;
            evt_kind  <= EV_EVICT;
            evt_id    <= ent_id[v_idx];
            evt_slot  <= v_idx;
          end
        end
        ST_LOAD: begin
          ent_valid[m_empty_idx]  <= 1'b1;
          ent_id[m_empty_idx]     <= cur_id;
          ent_size[m_empty_idx]   <= cur_size;
          ent_credit[m_empty_idx] <= cur_size;
          free_area <= AREA_W'(area_sub(32'(free_area), 32'(cur_size)));
          evt_valid <= 1'b1;
          evt_kind  <= EV_LOAD;
          evt_id    <= cur_id;
          evt_slot  <= m_empty_idx;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  p_area_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_area) <= AREA);

  p_hit_keeps_area_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_HIT) |-> $stable(free_area));

  p_load_costs_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_LOAD) |-> free_area < $past(free_area));

  p_evict_frees_area_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_EVICT) |-> free_area > $past(free_area));

  p_reject_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_REJECT) |-> ($stable(free_area) && $stable(ent_valid)));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !size_bad) |=> !req_ready);

  p_evict_needs_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVICT && !room) |-> v_found);

endmodule

// File: tb/ccache_credit_test.sv
module ccache_credit_test;
  localparam int SLOTS = 4;
  localparam int AREA  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_id = '0;
  logic [7:0] req_size = '0;
  logic       req_ready, evt_valid;
  logic [1:0] evt_kind;
  logic [7:0] evt_id;
  logic [1:0] evt_slot;
  logic [6:0] free_area;

  always #10 clk = ~clk;

  ccache_credit #(.SLOTS(SLOTS), .ID_W(8), .SIZE_W(8), .AREA(AREA)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_size(req_size), .req_ready(req_ready), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_id(evt_id), .evt_slot(evt_slot),
    .free_area(free_area)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  typedef struct {
    int    kind;
    int    id;
    int    slot;
    string tag;
  } exp_t;
  exp_t q[$];

  // Reference model
  int m_valid[SLOTS];
  int m_id[SLOTS];
  int m_size[SLOTS];
  int m_cred[SLOTS];
  int m_free;

  function automatic void model_reset();
    for (int i = 0; i < SLOTS; i++) begin
      m_valid[i] = 0; m_id[i] = 0; m_size[i] = 0; m_cred[i] = 0;
    end
    m_free = AREA;
  endfunction

  function automatic void push(input int k, input int id, input int s, input string tag);
    exp_t e;
    e.kind = k; e.id = id; e.slot = s; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void predict(input int id, input int size, input string tag);
    int hit_at = -1;
    if (size == 0 || size > AREA) begin
      push(3, id, 0, tag);
      return;
    end
    for (int i = 0; i < SLOTS; i++)
      if (m_valid[i] != 0 && m_id[i] == id && hit_at < 0) hit_at = i;
    if (hit_at >= 0) begin
      m_cred[hit_at] = m_size[hit_at];
      push(0, id, hit_at, tag);
      return;
    end
    for (int n = 0; n < SLOTS + 1; n++) begin
      int empty = -1;
      int v = -1;
      for (int i = SLOTS - 1; i >= 0; i--) if (m_valid[i] == 0) empty = i;
      if (empty >= 0 && m_free >= size) break;
      for (int i = 0; i < SLOTS; i++)
        if (m_valid[i] != 0 && (v < 0 || m_cred[i] < m_cred[v])) v = i;
      push(2, m_id[v], v, tag);
      m_free += m_size[v];
      m_valid[v] = 0;
      for (int i = 0; i < SLOTS; i++)
        if (m_valid[i] != 0) m_cred[i] = m_cred[i] - m_cred[v];
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (m_valid[i] == 0) begin
        m_valid[i] = 1; m_id[i] = id; m_size[i] = size; m_cred[i] = size;
        m_free -= size;
        push(1, id, i, tag);
        break;
      end
    end
  endfunction

  // Monitor: compare each event against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (q.size() == 0) begin
        chk(0, "R2/R3/R4/R9", "unexpected event kind", int'(evt_kind), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(evt_kind) == e.kind, e.tag, "event kind", int'(evt_kind), e.kind);
        chk(int'(evt_id) == e.id, e.tag, "event id", int'(evt_id), e.id);
        chk(int'(evt_slot) == e.slot, e.tag, "event slot", int'(evt_slot), e.slot);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    q.delete();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(free_area) == AREA, "R1", "free_area in reset", int'(free_area), AREA);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    chk(evt_valid == 1'b0, "R1", "evt_valid in reset", int'(evt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_req(input int id, input int size, input string tag);
    bit rej;
    rej = (size == 0 || size > AREA);
    predict(id, size, tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_id    = 8'(id);
    req_size  = 8'(size);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rej) chk(req_ready == 1'b0, "R10", "req_ready while busy", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(int'(free_area) == m_free, tag, "free_area after request", int'(free_area), m_free);
    chk(q.size() == 0, tag, "pending expected events", q.size(), 0);
  endtask

  initial begin
    do_reset();
    do_req(1, 30, "R3");          // slot0
    do_req(2, 20, "R3");          // slot1
    do_req(3, 40, "R3");          // slot2, free 10
    do_req(4, 50, "R4/R5/R6");    // evict id2 then id1, load slot0
    do_req(3, 40, "R2");          // hit, credit back to 40
    do_req(5, 5,  "R3");          // lowest empty slot1
    do_req(6, 1,  "R3");          // slot3, all slots full
    do_req(7, 1,  "R8");          // area free but no slot
    do_req(9, 101, "R9");         // too large
    do_req(9, 0,   "R9");         // zero area
    do_req(4, 50, "R2/R9");       // still resident after rejects
    do_req(8, 3,  "R8/R5");
    do_reset();
    do_req(10, 10, "R3");
    do_req(11, 10, "R3");
    do_req(12, 80, "R3");         // free 0
    do_req(13, 10, "R7");         // tie 10/10 -> slot0
    do_req(14, 15, "R5/R6");      // zero-credit victim, then another
    do_req(12, 80, "R2");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6", "queue drained at end", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule